// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic core of a byte-wide accumulator machine. An opcode selects one of eighteen operations. The operations read the accumulator, a second operand and the B register, and they return a new accumulator and a new B value in the same cycle. The datapath is purely combinational.

Carry, auxiliary carry and overflow are kept in a small flag register inside the block. Operations that need an incoming carry or auxiliary carry read it from this register. The register takes its new values on the clock edge where `valid_i` is high. Parity is not stored: it is derived continuously from the accumulator input. Instruction decode, operand fetch and write-back are left to the surrounding core.

The flag behaviour follows byte-machine conventions:
- The auxiliary carry is taken out of bit 3.
- A decimal-adjust step corrects a binary sum of two packed BCD bytes.
- Multiply splits its 16-bit product over A and B.
- Compare reports its result through the carry flag only.

Top module: `acc_alu`

## Requirements
- R1: While `rst_ni` is low, and right after it rises, `cy_o`, `ac_o` and `ov_o` are 0.
- R2: ADD (code 0) and ADDC (code 1) compute A + operand, plus CY for ADDC only.
  - CY is set on a carry out of bit 7.
  - AC is set on a carry out of bit 3.
  - OV is set when the signed result leaves the range -128..127.
- R3: SUBB (code 2) computes A - operand - CY.
  - CY is set on a borrow out of bit 7.
  - AC is set on a borrow out of bit 3.
  - OV is set when the signed difference leaves the range -128..127.
- R4: MUL (code 3) puts the high byte of the unsigned product A*B in B and the low byte in A. It clears CY, sets OV when the product exceeds 0xFF, and leaves AC unchanged.
- R5: DIV (code 4), with B nonzero, returns the unsigned quotient A/B in A and the remainder in B, and clears CY and OV. With B zero it sets OV, clears CY and passes A and B through unchanged. AC is unchanged in both cases.
- R6: DA (code 5) works in two steps, and its result is A after both.
  - Step 1: it adds 6 when the low nibble of A exceeds 9 or AC is set.
  - Step 2: it then adds 0x60 when the high nibble exceeds 9, when CY is set, or when step 1 carried out of bit 7.
  - CY becomes old CY OR any carry out of bit 7. AC and OV are unchanged.
- R7: AND (code 6), OR (code 7) and XOR (code 8) combine A with the operand bitwise, and CPL (code 9) inverts A. None of the four changes any flag.
- R8: The rotates come in two kinds:
  - RR (code 10) and RL (code 11) rotate A by one bit without touching the flags.
  - RRC (code 12) moves bit 0 into CY and the old CY into bit 7.
  - RLC (code 13) moves bit 7 into CY and the old CY into bit 0.
- R9: CMP (code 14) leaves A and B unchanged, sets CY exactly when A is below the operand (unsigned), and leaves AC and OV unchanged.
- R10: SETC (code 15) sets CY, CLRC (code 16) clears CY and CPLC (code 17) inverts CY. A is unchanged.
- R11: `par_o` is 1 exactly when `acc_i` holds an odd number of ones, in the same cycle.
- R12: With `valid_i` low the flags keep their values whatever the opcode. `b_o` equals `b_i` for every operation other than MUL and DIV.
- R13: Opcodes 18 to 31 leave A, B and all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Commit flag updates at this edge |
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator value |
| opd_i | input | 8 | Second operand |
| b_i | input | 8 | B register value |
| acc_o | output | 8 | New accumulator |
| b_o | output | 8 | New B register |
| cy_o | output | 1 | Carry flag |
| ac_o | output | 1 | Auxiliary carry flag |
| ov_o | output | 1 | Overflow flag |
| par_o | output | 1 | Parity of the accumulator input |

## Verification
The bench builds the block with the default 8-bit data width. At that width the whole add operand space can be swept exhaustively in one run.

Several operations are swept over every accumulator value:
- Subtract with borrow and add with carry, each with both incoming carry values.
- Multiply and divide, with divisor zero included.
- The logic operations, the rotates and compare.

Decimal adjust is checked end to end. The bench adds two packed BCD numbers and adjusts the sum, for 3400 pairs. It compares the result with the decimal sum modulo 100 and the carry with the hundreds digit.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,
    OP_ADDC = 5'd1,
    OP_SUBB = 5'd2,
    OP_MUL  = 5'd3,
    OP_DIV  = 5'd4,
    OP_DA   = 5'd5,
    OP_AND  = 5'd6,
    OP_OR   = 5'd7,
    OP_XOR  = 5'd8,
    OP_CPL  = 5'd9,
    OP_RR   = 5'd10,
    OP_RL   = 5'd11,
    OP_RRC  = 5'd12,
    OP_RLC  = 5'd13,
    OP_CMP  = 5'd14,
    OP_SETC = 5'd15,
    OP_CLRC = 5'd16,
    OP_CPLC = 5'd17
  } alu_op_e;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
  } alu_flags_t;
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  input  logic          sub_i,
  output logic [DW-1:0] sum_o,
  output logic          cy_o,
  output logic          ac_o,
  output logic          ov_o
);
  localparam int HW = 4;

  logic [DW-1:0] bx;
  logic          ci;
  logic [HW:0]   lo;
  logic [DW-1:0] lo_msb;
  logic [DW:0]   full;

  // subtract as a + ~b + ~borrow, carries inverted back into borrows
  assign bx     = sub_i ? ~b_i : b_i;
  assign ci     = sub_i ^ cin_i;
  assign lo     = {1'b0, a_i[HW-1:0]} + {1'b0, bx[HW-1:0]} + {{HW{1'b0}}, ci};
  assign lo_msb = {1'b0, a_i[DW-2:0]} + {1'b0, bx[DW-2:0]} + {{(DW-1){1'b0}}, ci};
  assign full   = {1'b0, a_i} + {1'b0, bx} + {{DW{1'b0}}, ci};

  assign sum_o = full[DW-1:0];
  assign cy_o  = full[DW] ^ sub_i;
  assign ac_o  = lo[HW] ^ sub_i;
  assign ov_o  = lo_msb[DW-1] ^ full[DW];
endmodule

// File: rtl/acc_alu_muldiv.sv
module acc_alu_muldiv #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] prod_lo_o,
  output logic [DW-1:0] prod_hi_o,
  output logic [DW-1:0] quo_o,
  output logic [DW-1:0] rem_o,
  output logic          mul_ov_o,
  output logic          dz_o
);
  localparam int PW = 2 * DW;

  logic [PW-1:0] prod;
  logic [DW:0]   part;
  logic [DW-1:0] quo;

  assign prod      = {{DW{1'b0}}, a_i} * {{DW{1'b0}}, b_i};
  assign prod_lo_o = prod[DW-1:0];
  assign prod_hi_o = prod[PW-1:DW];
  assign mul_ov_o  = |prod[PW-1:DW];
  assign dz_o      = (b_i == '0);

  // restoring division, one quotient bit per unrolled stage
  always_comb begin
    part = '0;
    quo  = '0;
    for (int i = DW - 1; i >= 0; i--) begin
      part = {part[DW-1:0], a_i[i]};
      if (part >= {1'b0, b_i}) begin
        part   = part - {1'b0, b_i};
        quo[i] = 1'b1;
      end
    end
  end

  assign quo_o = quo;
  assign rem_o = part[DW-1:0];
endmodule

// File: rtl/acc_alu_dadj.sv
module acc_alu_dadj #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic          cy_i,
  input  logic          ac_i,
  output logic [DW-1:0] res_o,
  output logic          cy_o
);
  localparam int NIB = DW / 4;

  logic [DW:0] v;

  // nibble corrections low to high; carries ripple through the sum
  always_comb begin
    v = {1'b0, a_i};
    for (int i = 0; i < NIB; i++) begin
      if ((v[4*i +: 4] > 4'd9) ||
          (i == 0 && ac_i) ||
          (i == NIB - 1 && (cy_i || v[DW])))
        v = v + ((DW+1)'(6) << (4 * i));
    end
  end

  assign res_o = v[DW-1:0];
  assign cy_o  = cy_i | v[DW];
endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags
  import acc_alu_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  alu_flags_t d_i,
  output alu_flags_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [OP_W-1:0] op_i,
  input  logic [DW-1:0]   acc_i,
  input  logic [DW-1:0]   opd_i,
  input  logic [DW-1:0]   b_i,
  output logic [DW-1:0]   acc_o,
  output logic [DW-1:0]   b_o,
  output logic            cy_o,
  output logic            ac_o,
  output logic            ov_o,
  output logic            par_o
);
  alu_op_e    op;
  alu_flags_t fl_q, fl_d;

  logic [DW-1:0] as_sum;
  logic          as_cy, as_ac, as_ov, as_cin, as_sub;
  logic [DW-1:0] p_lo, p_hi, quo, rem;
  logic          mul_ov, dz;
  logic [DW-1:0] da_res;
  logic          da_cy;
  logic [DW-1:0] acc_n, b_n;

  assign op     = alu_op_e'(op_i);
  assign as_sub = (op == OP_SUBB);
  assign as_cin = (op == OP_ADD) ? 1'b0 : fl_q.cy;

  acc_alu_addsub #(.DW(DW)) u_addsub (
    .a_i(acc_i), .b_i(opd_i), .cin_i(as_cin), .sub_i(as_sub),
    .sum_o(as_sum), .cy_o(as_cy), .ac_o(as_ac), .ov_o(as_ov)
  );

  acc_alu_muldiv #(.DW(DW)) u_muldiv (
    .a_i(acc_i), .b_i(b_i),
    .prod_lo_o(p_lo), .prod_hi_o(p_hi), .quo_o(quo), .rem_o(rem),
    .mul_ov_o(mul_ov), .dz_o(dz)
  );

  acc_alu_dadj #(.DW(DW)) u_dadj (
    .a_i(acc_i), .cy_i(fl_q.cy), .ac_i(fl_q.ac),
    .res_o(da_res), .cy_o(da_cy)
  );

  always_comb begin
    acc_n = acc_i;
    b_n   = b_i;
    fl_d  = fl_q;
    case (op)
      OP_ADD, OP_ADDC, OP_SUBB: begin
        acc_n   = as_sum;
        fl_d.cy = as_cy;
        fl_d.ac = as_ac;
        fl_d.ov = as_ov;
      end
      OP_MUL: begin
        acc_n   = p_lo;
        b_n     = p_hi;
        fl_d.cy = 1'b0;
        fl_d.ov = mul_ov;
      end
      OP_DIV: begin
        fl_d.cy = 1'b0;
        fl_d.ov = dz;
        if (!dz) begin
          acc_n = quo;
          b_n   = rem;
        end
      end
      OP_DA: begin
        acc_n   = da_res;
        fl_d.cy = da_cy;
      end
      OP_AND: acc_n = acc_i & opd_i;
      OP_OR:  acc_n = acc_i | opd_i;
      OP_XOR: acc_n = acc_i ^ opd_i;
      OP_CPL: acc_n = ~acc_i;
      OP_RR:  acc_n = {acc_i[0], acc_i[DW-1:1]};
      OP_RL:  acc_n = {acc_i[DW-2:0], acc_i[DW-1]};
      OP_RRC: begin
        acc_n   = {fl_q.cy, acc_i[DW-1:1]};
        fl_d.cy = acc_i[0];
      end
      OP_RLC: begin
        acc_n   = {acc_i[DW-2:0], fl_q.cy};
        fl_d.cy = acc_i[DW-1];
      end
      OP_CMP:  fl_d.cy = (acc_i < opd_i);
      OP_SETC: fl_d.cy = 1'b1;
      OP_CLRC: fl_d.cy = 1'b0;
      OP_CPLC: fl_d.cy = ~fl_q.cy;
      default: ;
    endcase
  end

  acc_alu_flags u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(valid_i),
    .d_i(fl_d), .q_o(fl_q)
  );

  assign acc_o = acc_n;
  assign b_o   = b_n;
  assign cy_o  = fl_q.cy;
  assign ac_o  = fl_q.ac;
  assign ov_o  = fl_q.ov;
  assign par_o = ^acc_i;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [OP_W-1:0] op_i,
  input logic [DW-1:0]   acc_i,
  input logic [DW-1:0]   b_i,
  input logic [DW-1:0]   acc_o,
  input logic [DW-1:0]   b_o,
  input logic            cy_o,
  input logic            ac_o,
  input logic            ov_o
);
  p_mul_clears_cy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_MUL |=> !cy_o);

  p_div_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_DIV && b_i == '0 |=> ov_o && !cy_o);

  p_logic_flags_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR || op_i == OP_CPL)
    |=> $stable({cy_o, ac_o, ov_o}));

  p_rotate_flags_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == OP_RR || op_i == OP_RL) |=> $stable({cy_o, ac_o, ov_o}));

  p_cmp_keeps_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_CMP |-> acc_o == acc_i && b_o == b_i);

  p_cmp_flags_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_CMP |=> $stable({ac_o, ov_o}));

  p_setc_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_SETC |=> cy_o);

  p_clrc_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_CLRC |=> !cy_o);

  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable({cy_o, ac_o, ov_o}));
endmodule

bind acc_alu acc_alu_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
  .acc_i(acc_i), .b_i(b_i), .acc_o(acc_o), .b_o(b_o),
  .cy_o(cy_o), .ac_o(ac_o), .ov_o(ov_o)
);

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 190000;

  localparam int ADD = 0, ADDC = 1, SUBB = 2, MUL = 3, DIV = 4, DA = 5;
  localparam int ANDO = 6, ORO = 7, XORO = 8, CPL = 9, RR = 10, RL = 11;
  localparam int RRC = 12, RLC = 13, CMP = 14, SETC = 15, CLRC = 16, CPLC = 17;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] acc = '0, opd = '0, breg = '0;
  logic [7:0] acc_o, b_o;
  logic       cy_o, ac_o, ov_o, par_o;

  int nchk = 0, nfail = 0, cyc = 0;
  int m_cy = 0, m_ac = 0, m_ov = 0;
  int last_acc = 0;

  acc_alu dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .acc_i(acc), .opd_i(opd), .b_i(breg),
    .acc_o(acc_o), .b_o(b_o), .cy_o(cy_o), .ac_o(ac_o), .ov_o(ov_o), .par_o(par_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog R1..R13 run: got %0d cycles exp fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  task automatic check(input string req, input string what, input int got, input int exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s %s: got %0h exp %0h", req, what, got, exp);
    end
  endtask

  function automatic int odd_ones(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return n & 1;
  endfunction

  function automatic int bcd(input int x);
    return (x / 10) * 16 + (x % 10);
  endfunction

  function automatic int sgn(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  task automatic exec(input int o_code, input int a, input int o, input int b);
    int ea, eb, ecy, eac, eov, cin, s, ss, v;
    string tag;
    ea = a; eb = b; ecy = m_cy; eac = m_ac; eov = m_ov; tag = "R13";
    case (o_code)
      ADD, ADDC: begin
        tag = "R2";
        cin = (o_code == ADDC) ? m_cy : 0;
        s   = a + o + cin;
        ss  = sgn(a) + sgn(o) + cin;
        ea  = s & 255; ecy = (s > 255);
        eac = (((a & 15) + (o & 15) + cin) > 15);
        eov = (ss > 127 || ss < -128);
      end
      SUBB: begin
        tag = "R3";
        cin = m_cy;
        s   = a - o - cin;
        ss  = sgn(a) - sgn(o) - cin;
        ea  = s & 255; ecy = (s < 0);
        eac = (((a & 15) - (o & 15) - cin) < 0);
        eov = (ss > 127 || ss < -128);
      end
      MUL: begin
        tag = "R4";
        s = a * b; ea = s & 255; eb = s >> 8; ecy = 0; eov = (s > 255);
      end
      DIV: begin
        tag = "R5";
        ecy = 0;
        if (b == 0) eov = 1;
        else begin ea = a / b; eb = a % b; eov = 0; end
      end
      DA: begin
        tag = "R6";
        v = a;
        if ((v & 15) > 9 || m_ac) v += 6;
        if (((v >> 4) & 15) > 9 || m_cy || v > 255) v += 96;
        ecy = m_cy | (v > 255); ea = v & 255;
      end
      ANDO: begin tag = "R7"; ea = a & o; end
      ORO:  begin tag = "R7"; ea = a | o; end
      XORO: begin tag = "R7"; ea = a ^ o; end
      CPL:  begin tag = "R7"; ea = ~a & 255; end
      RR:   begin tag = "R8"; ea = ((a >> 1) | (a << 7)) & 255; end
      RL:   begin tag = "R8"; ea = ((a << 1) | (a >> 7)) & 255; end
      RRC:  begin tag = "R8"; ea = (a >> 1) | (m_cy << 7); ecy = a & 1; end
      RLC:  begin tag = "R8"; ea = ((a << 1) & 255) | m_cy; ecy = (a >> 7) & 1; end
      CMP:  begin tag = "R9"; ecy = (a < o); end
      SETC: begin tag = "R10"; ecy = 1; end
      CLRC: begin tag = "R10"; ecy = 0; end
      CPLC: begin tag = "R10"; ecy = 1 - m_cy; end
      default: ;
    endcase
    @(negedge clk);
    op = o_code[4:0]; acc = a[7:0]; opd = o[7:0]; breg = b[7:0]; valid = 1'b1;
    #1;
    check(tag, "acc", int'(acc_o), ea);
    check((o_code == MUL || o_code == DIV) ? tag : "R12", "b", int'(b_o), eb);
    check("R11", "parity", int'(par_o), odd_ones(a));
    @(posedge clk);
    #1;
    valid = 1'b0;
    check(tag, "cy", int'(cy_o), ecy);
    check(tag, "ac", int'(ac_o), eac);
    check(tag, "ov", int'(ov_o), eov);
    m_cy = ecy; m_ac = eac; m_ov = eov; last_acc = ea;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1", "cy in reset", int'(cy_o), 0);
    check("R1", "ac in reset", int'(ac_o), 0);
    check("R1", "ov in reset", int'(ov_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1", "cy after reset", int'(cy_o), 0);
    check("R1", "ov after reset", int'(ov_o), 0);

    // worked examples
    exec(ADD, 8'h47, 8'h25, 0);
    check("R6", "bcd pre-sum", last_acc, 8'h6C);
    exec(DA, 8'h6C, 0, 0);
    check("R6", "bcd 47+25", int'(acc_o), 8'h72);
    exec(MUL, 8'h25, 0, 8'h65);
    check("R4", "mul hi", int'(b_o), 8'h0E);
    exec(DIV, 95, 0, 10);
    check("R5", "div quotient", int'(acc_o), 9);
    check("R5", "div remainder", int'(b_o), 5);

    // R2: exhaustive add, then add with carry both ways
    for (int a = 0; a < 256; a++)
      for (int o = 0; o < 256; o++) exec(ADD, a, o, o ^ 8'h3C);
    for (int a = 0; a < 256; a++)
      for (int o = 0; o < 256; o += 13)
        for (int c = 0; c < 2; c++) begin
          exec(c ? SETC : CLRC, a, o, 0);
          exec(ADDC, a, o, a);
        end

    // R3: subtract with borrow
    for (int a = 0; a < 256; a++)
      for (int o = 0; o < 256; o += 13)
        for (int c = 0; c < 2; c++) begin
          exec(c ? SETC : CLRC, a, o, 0);
          exec(SUBB, a, o, o);
        end

    // R4, R5: multiply and divide, divisor zero included
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 9) begin
        exec(MUL, a, 0, b);
        exec(DIV, a, 0, b);
      end
    exec(MUL, 255, 0, 255);
    exec(DIV, 200, 0, 0);
    exec(DIV, 0, 0, 0);

    // R6: BCD add then adjust, compared with decimal arithmetic
    for (int x = 0; x < 100; x++)
      for (int y = 0; y < 100; y += 3) begin
        exec(ADD, bcd(x), bcd(y), 0);
        exec(DA, last_acc, 0, 0);
        check("R6", "decimal sum", last_acc, bcd((x + y) % 100));
        check("R6", "decimal carry", m_cy, int'(x + y >= 100));
      end
    exec(ADD, 0, 0, 0);
    exec(DA, 8'h9A, 0, 0);
    check("R6", "9A adjust", last_acc, 0);
    exec(CLRC, 0, 0, 0);
    exec(DA, 8'hFA, 0, 0);
    check("R6", "FA adjust", last_acc, 8'h60);

    // R7: logic ops keep flags
    exec(ADD, 8'h8F, 8'h81, 0);
    for (int a = 0; a < 256; a++) begin
      for (int k = 0; k < 8; k++) begin
        int o;
        o = (k == 0) ? 8'h00 : (k == 1) ? 8'h0F : (k == 2) ? 8'hF0 : (k == 3) ? 8'h55 :
            (k == 4) ? 8'hAA : (k == 5) ? 8'hFF : (k == 6) ? 8'h5A : 8'hC3;
        exec(ANDO, a, o, 0);
        exec(ORO, a, o, 0);
        exec(XORO, a, o, 0);
      end
      exec(CPL, a, a, 0);
    end

    // R8: rotates with each incoming carry
    for (int a = 0; a < 256; a++)
      for (int c = 0; c < 2; c++) begin
        exec(c ? SETC : CLRC, a, 0, 0);
        exec(RR, a, 0, 0);
        exec(RL, a, 0, 0);
        exec(RRC, a, 0, 0);
        exec(c ? SETC : CLRC, a, 0, 0);
        exec(RLC, a, 0, 0);
      end

    // R9: compare, equal operands included
    exec(SUBB, 8'h10, 8'h01, 0);
    for (int a = 0; a < 256; a++) begin
      exec(CMP, a, a, 8'h77);
      for (int o = 0; o < 256; o += 7) exec(CMP, a, o, a);
    end

    // R10: carry operations
    exec(CLRC, 8'h21, 0, 0);
    exec(CPLC, 8'h21, 0, 0);
    exec(CPLC, 8'h21, 0, 0);
    exec(SETC, 8'h21, 0, 0);
    exec(SETC, 8'h21, 0, 0);

    // R12: flags hold while valid is low; R13: unused codes
    exec(ADD, 8'h80, 8'h80, 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      op = (k == 0) ? 5'd16 : (k == 1) ? 5'd0 : (k == 2) ? 5'd3 : 5'd4;
      acc = 8'h7F; opd = 8'h01; breg = 8'h00; valid = 1'b0;
      @(posedge clk);
      #1;
      check("R12", "cy held", int'(cy_o), m_cy);
      check("R12", "ac held", int'(ac_o), m_ac);
      check("R12", "ov held", int'(ov_o), m_ov);
    end
    for (int c = 18; c < 32; c++) exec(c, c * 7, 8'hFF, c);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule